// File: doc/BRIEF.md
# Start-Byte Framed Serial Slave

This block is a three-wire serial slave for a host that drives a strobe, a serial clock and one shared data line. Each transaction is framed by the strobe: it starts when the strobe falls and is closed when the strobe rises. Inside that frame the host sends a start byte and then a second byte. When the host writes, it sends the second byte. When the host reads, the slave returns it on the same line. Bits are carried most significant first.

A faster system clock oversamples the strobe, the serial clock and the incoming data. A write reaches the core as a one-cycle request that carries the byte and a tag saying whether it is an instruction or data. A read reaches the core as a one-cycle request as soon as the start byte decodes, so that the core can put its response byte in place before the first data bit is due. The slave then drives that byte and controls the pad direction. The pad itself sits outside the block.

The start byte is eight bits: five ones, then the direction flag, then the tag flag, then a zero. The host side needs at least 200 ns for each serial-clock phase and at least 1 µs between the two bytes.

Top module: `strobe_serial_slave`

## Requirements
- R1: After reset, `wr_req_o`, `rd_req_o`, `ser_dout_o` and `ser_dout_oe_o` are low.
- R2: The start byte is sampled on rising serial-clock edges, most significant bit first. Its bits 7..3 must be ones and bit 0 must be zero. Bit 2 is the direction flag (1 = read, 0 = write). Bit 1 is the tag flag (0 = instruction, 1 = data).
- R3: In a write frame with exactly 16 rising edges and a valid start byte, the strobe's rising edge produces one `wr_req_o` pulse. `wr_byte_o` then holds the second byte, sampled on rising edges with its most significant bit first, and `wr_is_data_o` holds the tag flag.
- R4: A write frame closed after fewer or more than 16 rising edges produces no request.
- R5: If the start byte has a zero in bits 7..3 or a one in bit 0, the rest of the frame is ignored. There is no request and the data line stays undriven. The next frame decodes normally.
- R6: A valid read start byte produces one `rd_req_o` pulse with `rd_is_data_o` equal to the tag flag. The pulse follows the eighth rising edge and comes before any falling edge of the data byte.
- R7: In a read frame, `resp_byte_i` is captured on the first falling edge after the start byte. Its bit 7 is driven on that edge and each later falling edge drives the next lower bit. `ser_dout_oe_o` rises on that first falling edge and falls when the strobe rises.
- R8: Serial-clock edges while the strobe is high produce no request and no drive.
- R9: A read frame never produces `wr_req_o`, whatever its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_stb_i | input | 1 | Frame strobe, low during a frame |
| ser_clk_i | input | 1 | Serial clock from the host, idles high |
| ser_din_i | input | 1 | Serial data from the pad receiver |
| resp_byte_i | input | 8 | Response byte from the core for read frames |
| ser_dout_o | output | 1 | Serial data toward the pad driver |
| ser_dout_oe_o | output | 1 | Pad driver enable |
| wr_req_o | output | 1 | One-cycle write request |
| wr_byte_o | output | 8 | Written byte, valid with `wr_req_o` |
| wr_is_data_o | output | 1 | Tag of the written byte, 1 = data |
| rd_req_o | output | 1 | One-cycle read request |
| rd_is_data_o | output | 1 | Tag of the read, 1 = data |

## Verification
Writes are run with walking-one and walking-zero bytes and with all-zero and all-one bytes, each under both tags. This separates bit order, bit position and tag routing. Reads return a set of response bytes that differ in one bit each, which exposes shift-order and off-by-one-edge faults in the return path. Start bytes that each have one prefix bit or the trailing bit corrupted test every sync check on its own. Frames of 8, 15 and 17 edges, and serial clocking while the strobe is idle, show that only an exact, closed frame is committed.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
  localparam int SSL_BYTE_W = 8;
  localparam int SSL_TAIL_W = 3;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_BODY  = 2'd2,
    PH_DROP  = 2'd3
  } ssl_phase_t;
endpackage

// File: rtl/ssl_in_sync.sv
module ssl_in_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= pin_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign lvl_o = stg_q[STAGES-1];
endmodule

// File: rtl/ssl_frame_ctl.sv
module ssl_frame_ctl
  import ssl_pkg::*;
#(
  parameter int BYTE_W = SSL_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_fall,
  input  logic              stb_rise,
  input  logic              sclk_rise,
  input  logic              sdi_s,
  output logic              wr_req,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              wr_is_data,
  output logic              rd_req,
  output logic              rd_is_data,
  output logic              read_phase
);
  localparam int FRAME_BITS = 2 * BYTE_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(BYTE_W - 1);

  ssl_phase_t        phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sr_q, sr_d;
  logic              rw_q, rw_d, rs_q, rs_d;
  logic              wr_req_q, wr_req_d, rd_req_q, rd_req_d;
  logic [BYTE_W-1:0] wr_byte_q;
  logic              wr_tag_q, rd_tag_q;
  logic [BYTE_W-1:0] shift_in;
  logic              hdr_ok;

  assign shift_in = {sr_q[BYTE_W-2:0], sdi_s};
  assign hdr_ok   = (&shift_in[BYTE_W-1:SSL_TAIL_W]) && !shift_in[0];

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    sr_d     = sr_q;
    rw_d     = rw_q;
    rs_d     = rs_q;
    wr_req_d = 1'b0;
    rd_req_d = 1'b0;
    if (stb_fall) begin
      phase_d = PH_START;
      cnt_d   = '0;
      rw_d    = 1'b0;
    end else if (stb_rise) begin
      wr_req_d = (phase_q == PH_BODY) && !rw_q && (cnt_q == CNT_FULL);
      phase_d  = PH_IDLE;
    end else if (sclk_rise && (phase_q == PH_START || phase_q == PH_BODY)) begin
      sr_d = shift_in;
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
      if (phase_q == PH_START && cnt_q == CNT_HDR) begin
        if (hdr_ok) begin
          phase_d  = PH_BODY;
          rw_d     = shift_in[2];
          rs_d     = shift_in[1];
          rd_req_d = shift_in[2];
        end else begin
          phase_d = PH_DROP;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      sr_q      <= '0;
      rw_q      <= 1'b0;
      rs_q      <= 1'b0;
      wr_req_q  <= 1'b0;
      rd_req_q  <= 1'b0;
      wr_byte_q <= '0;
      wr_tag_q  <= 1'b0;
      rd_tag_q  <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      sr_q     <= sr_d;
      rw_q     <= rw_d;
      rs_q     <= rs_d;
      wr_req_q <= wr_req_d;
      rd_req_q <= rd_req_d;
      if (wr_req_d) begin
        wr_byte_q <= sr_q;
        wr_tag_q  <= rs_q;
      end
      if (rd_req_d) rd_tag_q <= rs_d;
    end
  end

  assign wr_req     = wr_req_q;
  assign wr_byte    = wr_byte_q;
  assign wr_is_data = wr_tag_q;
  assign rd_req     = rd_req_q;
  assign rd_is_data = rd_tag_q;
  assign read_phase = (phase_q == PH_BODY) && rw_q;

  // R3
  wr_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> $past(stb_rise));
  // R6
  rd_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> $past(sclk_rise));
  // R6
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  // R9
  rd_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (read_phase && stb_rise) |=> !wr_req);
endmodule

// File: rtl/ssl_tx_shift.sv
module ssl_tx_shift
  import ssl_pkg::*;
#(
  parameter int BYTE_W = SSL_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              read_phase,
  input  logic              sclk_fall,
  input  logic              stb_rise,
  input  logic [BYTE_W-1:0] resp_data,
  output logic              sdo,
  output logic              sdo_oe
);
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              loaded_q, loaded_d;
  logic              oe_q, oe_d;
  logic              sdo_q, sdo_d;

  always_comb begin
    sh_d     = sh_q;
    loaded_d = loaded_q;
    oe_d     = oe_q;
    sdo_d    = sdo_q;
    if (stb_rise || !read_phase) begin
      loaded_d = 1'b0;
      oe_d     = 1'b0;
    end else if (sclk_fall) begin
      oe_d     = 1'b1;
      loaded_d = 1'b1;
      if (!loaded_q) begin
        sdo_d = resp_data[BYTE_W-1];
        sh_d  = {resp_data[BYTE_W-2:0], 1'b0};
      end else begin
        sdo_d = sh_q[BYTE_W-1];
        sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      loaded_q <= 1'b0;
      oe_q     <= 1'b0;
      sdo_q    <= 1'b0;
    end else begin
      sh_q     <= sh_d;
      loaded_q <= loaded_d;
      oe_q     <= oe_d;
      sdo_q    <= sdo_d;
    end
  end

  assign sdo    = sdo_q;
  assign sdo_oe = oe_q;

  // R7
  oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rise |=> !sdo_oe);
  // R7
  oe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(sclk_fall));
  // R7
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && !sclk_fall) |=> (!sdo_oe || $stable(sdo)));
endmodule

// File: rtl/strobe_serial_slave.sv
module strobe_serial_slave
  import ssl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ser_stb_i,
  input  logic                  ser_clk_i,
  input  logic                  ser_din_i,
  input  logic [SSL_BYTE_W-1:0] resp_byte_i,
  output logic                  ser_dout_o,
  output logic                  ser_dout_oe_o,
  output logic                  wr_req_o,
  output logic [SSL_BYTE_W-1:0] wr_byte_o,
  output logic                  wr_is_data_o,
  output logic                  rd_req_o,
  output logic                  rd_is_data_o
);
  localparam int PIN_N = 3;
  localparam logic [PIN_N-1:0] PIN_IDLE = 3'b011; // {data, clock, strobe}

  logic [PIN_N-1:0] pin_s;
  logic stb_prev_q, clk_prev_q;
  logic stb_fall, stb_rise, sclk_rise, sclk_fall;
  logic read_phase;

  ssl_in_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i ({ser_din_i, ser_clk_i, ser_stb_i}),
    .lvl_o (pin_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_prev_q <= PIN_IDLE[0];
      clk_prev_q <= PIN_IDLE[1];
    end else begin
      stb_prev_q <= pin_s[0];
      clk_prev_q <= pin_s[1];
    end
  end

  assign stb_fall  =  stb_prev_q & ~pin_s[0];
  assign stb_rise  = ~stb_prev_q &  pin_s[0];
  assign sclk_rise = ~clk_prev_q &  pin_s[1];
  assign sclk_fall =  clk_prev_q & ~pin_s[1];

  ssl_frame_ctl #(.BYTE_W(SSL_BYTE_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb_fall   (stb_fall),
    .stb_rise   (stb_rise),
    .sclk_rise  (sclk_rise),
    .sdi_s      (pin_s[2]),
    .wr_req     (wr_req_o),
    .wr_byte    (wr_byte_o),
    .wr_is_data (wr_is_data_o),
    .rd_req     (rd_req_o),
    .rd_is_data (rd_is_data_o),
    .read_phase (read_phase)
  );

  ssl_tx_shift #(.BYTE_W(SSL_BYTE_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .read_phase (read_phase),
    .sclk_fall  (sclk_fall),
    .stb_rise   (stb_rise),
    .resp_data  (resp_byte_i),
    .sdo        (ser_dout_o),
    .sdo_oe     (ser_dout_oe_o)
  );

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_prev_q && pin_s[0]) |=> (!rd_req_o && !ser_dout_oe_o));
endmodule

// File: tb/test_strobe_serial_slave.sv
module test_strobe_serial_slave;
  localparam int HALF = 20;
  localparam int GAP  = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic [7:0] resp = 8'h00;
  logic sdo, sdo_oe, wr_req, wr_tag, rd_req, rd_tag;
  logic [7:0] wr_byte;

  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [7:0] last_wr = 8'h00;
  logic last_wr_tag = 1'b0, last_rd_tag = 1'b0, oe_seen = 1'b0;

  always #5 clk = ~clk;

  strobe_serial_slave i_strobe_serial_slave (
    .clk(clk), .rst_n(rst_n), .ser_stb_i(stb), .ser_clk_i(sclk),
    .ser_din_i(sdi), .resp_byte_i(resp), .ser_dout_o(sdo),
    .ser_dout_oe_o(sdo_oe), .wr_req_o(wr_req), .wr_byte_o(wr_byte),
    .wr_is_data_o(wr_tag), .rd_req_o(rd_req), .rd_is_data_o(rd_tag)
  );

  always @(negedge clk) begin
    if (wr_req) begin
      wr_cnt++; last_wr = wr_byte; last_wr_tag = wr_tag;
    end
    if (rd_req) begin
      rd_cnt++; last_rd_tag = rd_tag;
    end
    if (sdo_oe) oe_seen = 1'b1;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Sends nbits bits: the start byte, a gap, then db (zeros past 8 data bits).
  // Samples the line after each data-phase falling edge.
  task automatic run_frame(input logic [7:0] sb, input int nbits, input logic [7:0] db,
                           output logic [7:0] rx, output int rd_before);
    rx = 8'h00;
    rd_before = rd_cnt;
    oe_seen = 1'b0;
    stb = 1'b0;
    tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      if (i == 8) begin
        tick(GAP);
        rd_before = rd_cnt;
      end
      sclk = 1'b0;
      sdi = (i < 8) ? sb[7-i] : ((i < 16) ? db[15-i] : 1'b0);
      tick(HALF);
      if (i >= 8 && i < 16) rx[15-i] = sdo;
      sclk = 1'b1;
      tick(HALF);
    end
    if (nbits == 8) begin
      tick(GAP);
      rd_before = rd_cnt;
    end
    tick(HALF);
    stb = 1'b1;
    tick(10);
  endtask

  task automatic write_case(input logic rs, input logic [7:0] d);
    int w0, r0, rb;
    logic [7:0] rx;
    w0 = wr_cnt; r0 = rd_cnt;
    run_frame({5'b11111, 1'b0, rs, 1'b0}, 16, d, rx, rb);
    chk(wr_cnt == w0 + 1, "R3 write pulse count", wr_cnt - w0, 1);
    chk(last_wr == d, "R3 written byte", last_wr, d);
    chk(last_wr_tag == rs, "R2 tag flag", last_wr_tag, rs);
    chk(rd_cnt == r0 && !oe_seen, "R2 write is not a read", rd_cnt - r0, 0);
  endtask

  task automatic read_case(input logic rs, input logic [7:0] d);
    int w0, r0, rb;
    logic [7:0] rx;
    w0 = wr_cnt; r0 = rd_cnt; resp = d;
    run_frame({5'b11111, 1'b1, rs, 1'b0}, 16, 8'hC3, rx, rb);
    chk(rb == r0 + 1, "R6 read request before data", rb - r0, 1);
    chk(rd_cnt == r0 + 1, "R6 single read pulse", rd_cnt - r0, 1);
    chk(last_rd_tag == rs, "R6 read tag", last_rd_tag, rs);
    chk(rx == d, "R7 returned byte", rx, d);
    chk(!sdo_oe, "R7 driver off after strobe", sdo_oe, 0);
    chk(wr_cnt == w0, "R9 no write from read", wr_cnt - w0, 0);
  endtask

  task automatic none_case(input logic [7:0] sb, input int nbits, input string req);
    int w0, r0, rb;
    logic [7:0] rx;
    w0 = wr_cnt; r0 = rd_cnt;
    run_frame(sb, nbits, 8'h96, rx, rb);
    chk(wr_cnt == w0, req, wr_cnt - w0, 0);
    chk(rd_cnt == r0 && !oe_seen, req, rd_cnt - r0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1
    chk(!wr_req && !rd_req, "R1 requests idle", {wr_req, rd_req}, 0);
    chk(!sdo && !sdo_oe, "R1 line idle", {sdo, sdo_oe}, 0);

    for (int rs = 0; rs < 2; rs++) begin
      for (int b = 0; b < 8; b++) begin
        write_case(rs[0], 8'(1 << b));
        write_case(rs[0], ~8'(1 << b));
      end
      write_case(rs[0], 8'h00);
      write_case(rs[0], 8'hFF);
    end

    for (int rs = 0; rs < 2; rs++) begin
      for (int b = 0; b < 8; b++) read_case(rs[0], 8'h5A ^ 8'(1 << b));
      read_case(rs[0], 8'h00);
      read_case(rs[0], 8'hFF);
    end

    // R5: one corrupted sync bit at a time, then a good frame
    for (int p = 0; p < 8; p++) begin
      if (p == 1 || p == 2) continue;
      none_case(8'hFA ^ 8'(1 << p), 16, "R5 bad write header ignored");
      none_case(8'hFC ^ 8'(1 << p), 16, "R5 bad read header ignored");
    end
    write_case(1'b1, 8'h3C);

    // R4: wrong frame lengths
    none_case(8'hFA, 15, "R4 short frame");
    none_case(8'hF8, 8, "R4 header-only frame");
    none_case(8'hFA, 17, "R4 long frame");
    write_case(1'b0, 8'hE1);

    // R9: read frame closed early or late
    begin
      int w0, rb;
      logic [7:0] rx;
      w0 = wr_cnt;
      run_frame(8'hFE & 8'hFC, 17, 8'h00, rx, rb);
      chk(wr_cnt == w0, "R9 long read no write", wr_cnt - w0, 0);
    end

    // R8: clocking with strobe high
    begin
      int w0, r0;
      w0 = wr_cnt; r0 = rd_cnt; oe_seen = 1'b0;
      for (int i = 0; i < 16; i++) begin
        sclk = 1'b0; sdi = (i < 8) ? 8'hFC >> (7 - i) : 1'b1;
        tick(HALF);
        sclk = 1'b1;
        tick(HALF);
      end
      tick(10);
      chk(wr_cnt == w0 && rd_cnt == r0, "R8 idle clocking ignored", wr_cnt - w0 + rd_cnt - r0, 0);
      chk(!oe_seen, "R8 no drive when idle", oe_seen, 0);
    end
    write_case(1'b1, 8'h81);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule